// File: doc/BRIEF.md
# Digital Audio Subframe Encoder

This block turns parallel audio samples and per-subframe side bits into a biphase-mark coded, two-channel digital audio stream on a differential pair. Each subframe has 32 slots. Four preamble slots are followed by a 24-bit audio field with the auxiliary bits included, then the validity, user, channel-status and parity bits. Frames hold two subframes, and 192 frames form one channel-status block. The encoder keeps the half-cell, channel and frame counters. It also inserts the three preamble kinds and makes the parity bit. When CRC insertion is enabled, it computes a separate channel-status check byte for each channel and sends it in the last eight frames of the block.

The source reads `sf_frame` and `sf_chan_b`, which give the subframe about to be loaded. It then drives the matching audio word, channel-status bit and user bit. Half-cell timing comes from the master clock through a fractional divider, so a frame lasts 128, 192, 256 or 384 master clocks. The counters start only after an active frame-sync edge. In left/right sync mode that edge is the start of the right sample, so channel A carries left audio.

Top module: `audio_subframe_tx`

## Requirements
- R1: While `rst_n` is low, and after release until the first half-cell is sent, `tx_p` and `tx_n` are both low. Once running they are always complementary.
- R2: With `lr_mode` low, a rising edge on `fsync` starts the block. The first half-cell appears at the edge START_DLY+1 clocks after the clock edge that samples `fsync` high.
- R3: With `lr_mode` high, rising `fsync` edges are ignored. A falling edge starts the block with the same latency as in R2.
- R4: Each subframe opens with 8 half-cells. Relative to the line level before the subframe (first half-cell listed first), these are 11101000 for channel A of frame 0 (block start), 11100010 for the other channel-A subframes, and 11100100 for every channel-B subframe. The frame counter runs 0 to 191 and wraps.
- R5: From slot 4 to slot 31 the line changes at every cell boundary, and also mid-cell when the bit is 1. The first preamble half-cell differs from the level before it.
- R6: Slots 4 to 27 carry the audio word LSB first (bit 0 in slot 4). Slot 28 carries validity, slot 29 the user bit and slot 30 the channel-status bit. The audio word for channel A is `aud_a` and for channel B is `aud_b`.
- R7: Slot 31 makes the number of ones in slots 4 to 31 even.
- R8: While `audio_on` is low, slots 4 to 27 are sent as zero. Validity, user, channel-status and parity are still sent.
- R9: Slot 28 equals `valid_bit`. A value of 0 marks the sample as fit for conversion to analog.
- R10: With `crc_en` high, frames 184 to 191 carry a per-channel check byte in slot 30, MSB in frame 184. The byte starts from 0xFF and is updated serially over the channel-status bits of frames 0 to 183. The update is: feedback = bit XOR crc[7], then crc = (crc<<1) XOR (feedback ? 0x1D : 0), which is the generator x^8+x^4+x^3+x^2+1. With `crc_en` low, those frames send `cs_bit`.
- R11: `mck_sel` codes 0, 1, 2 and 3 give frame lengths of 128, 192, 256 and 384 master clocks.
- R12: A reset in mid-block restarts at channel A of frame 0 with a block-start preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | synchronous reset, active low |
| fsync | input | 1 | input frame sync |
| lr_mode | input | 1 | 1: fsync high marks left, start on falling edge |
| mck_sel | input | 2 | master clock to word rate ratio select |
| audio_on | input | 1 | 0 forces the audio field to zero |
| valid_bit | input | 1 | validity bit sent in every subframe |
| crc_en | input | 1 | channel-status check byte insertion |
| aud_a | input | 24 | channel A sample with auxiliary bits |
| aud_b | input | 24 | channel B sample with auxiliary bits |
| user_bit | input | 1 | user bit for the next subframe |
| cs_bit | input | 1 | channel-status bit for the next subframe |
| tx_p | output | 1 | coded line, true side |
| tx_n | output | 1 | coded line, complement side |
| sf_chan_b | output | 1 | next subframe is channel B |
| sf_frame | output | 8 | frame index of the next subframe |

## Verification
The bench builds the encoder with START_DLY set to 5. This keeps the start-up waits short, so exact latency can be checked in both sync modes, including a rising-edge window that must stay quiet. Two full 192-frame blocks are decoded at the 128x ratio: one with CRC insertion on and one muted with CRC off. This exercises the frame-counter wrap, the block-start preamble and both checksum bytes. All four ratio codes are measured by timing the channel indicator.

// File: rtl/audio_subframe_tx.sv
module audio_subframe_tx #(
  parameter int START_DLY = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fsync,
  input  logic        lr_mode,
  input  logic [1:0]  mck_sel,
  input  logic        audio_on,
  input  logic        valid_bit,
  input  logic        crc_en,
  input  logic [23:0] aud_a,
  input  logic [23:0] aud_b,
  input  logic        user_bit,
  input  logic        cs_bit,
  output logic        tx_p,
  output logic        tx_n,
  output logic        sf_chan_b,
  output logic [7:0]  sf_frame
);
  localparam int DW = (START_DLY < 2) ? 1 : $clog2(START_DLY);
  localparam logic [7:0] LAST_FR = 8'd191;
  localparam logic [7:0] CRC_FR  = 8'd184;

  logic          fs_q, waiting, run, act, line, lvl0;
  logic [DW-1:0] dly;
  logic [2:0]    acc, kval;
  logic [5:0]    hc;
  logic [27:0]   dat;
  logic [7:0]    crc_a, crc_b, pre;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = b ^ c[7];
    return {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
  endfunction

  always_comb
    case (mck_sel)
      2'd0:    kval = 3'd2;
      2'd1:    kval = 3'd3;
      2'd2:    kval = 3'd4;
      default: kval = 3'd6;
    endcase

  wire        fs_edge = lr_mode ? (fs_q & ~fsync) : (fsync & ~fs_q);
  wire [3:0]  asum    = {1'b0, acc} + 4'd2;
  wire        tick    = run && (asum >= {1'b0, kval});

  wire [4:0]  slot    = hc[5:1];
  wire [4:0]  didx    = slot - 5'd4;
  wire [23:0] aud     = audio_on ? (sf_chan_b ? aud_b : aud_a) : 24'd0;
  wire [7:0]  crc_cur = sf_chan_b ? crc_b : crc_a;
  wire        c_out   = (crc_en && sf_frame >= CRC_FR) ? crc_cur[3'd7 - sf_frame[2:0]] : cs_bit;
  wire [26:0] body    = {c_out, user_bit, valid_bit, aud};
  wire [27:0] word    = {^body, body};
  wire [7:0]  crc_nxt = crc_step((sf_frame == 8'd0) ? 8'hFF : crc_cur, cs_bit);
  wire        lvl     = (hc == 6'd0) ? line : lvl0;

  always_comb
    if (sf_chan_b)             pre = 8'b11100100;
    else if (sf_frame == 8'd0) pre = 8'b11101000;
    else                       pre = 8'b11100010;

  logic nline;
  always_comb
    if (slot < 5'd4)  nline = pre[3'd7 - hc[2:0]] ^ lvl;
    else if (!hc[0])  nline = ~line;
    else              nline = line ^ dat[didx];

  always_ff @(posedge clk) begin
    fs_q <= fsync;
    if (!rst_n) begin
      waiting <= 1'b0; run <= 1'b0; act <= 1'b0; line <= 1'b0; lvl0 <= 1'b0;
      dly <= '0; acc <= '0; hc <= '0; dat <= '0;
      crc_a <= 8'hFF; crc_b <= 8'hFF; sf_chan_b <= 1'b0; sf_frame <= 8'd0;
    end else begin
      if (!run && !waiting && fs_edge) begin
        waiting <= 1'b1;
        dly     <= '0;
      end else if (waiting) begin
        if (dly == DW'(START_DLY - 1)) begin
          run     <= 1'b1;
          waiting <= 1'b0;
        end else
          dly <= dly + 1'b1;
      end
      if (run) acc <= tick ? 3'(asum - {1'b0, kval}) : asum[2:0];
      if (tick) begin
        act  <= 1'b1;
        line <= nline;
        hc   <= hc + 6'd1;
        if (hc == 6'd0) begin
          dat  <= word;
          lvl0 <= line;
          if (sf_frame < CRC_FR) begin
            if (sf_chan_b) crc_b <= crc_nxt;
            else           crc_a <= crc_nxt;
          end
        end
        if (hc == 6'd63) begin
          sf_chan_b <= ~sf_chan_b;
          if (sf_chan_b) sf_frame <= (sf_frame == LAST_FR) ? 8'd0 : sf_frame + 8'd1;
        end
      end
    end
  end

  assign tx_p = act & line;
  assign tx_n = act & ~line;
endmodule

// File: rtl/audio_subframe_tx_chk.sv
module audio_subframe_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_p,
  input logic       tx_n,
  input logic       sf_chan_b,
  input logic [7:0] sf_frame,
  input logic       tick,
  input logic       act,
  input logic [5:0] hc
);
  a_r1_never_both_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_p && tx_n));

  a_r5_cell_edge_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hc[5:1] >= 5'd4 && !hc[0]) |=> (tx_p != $past(tx_p)));

  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sf_frame) && sf_frame == 8'd0) |-> ($past(sf_frame) == 8'd191));

  a_r4_frame_after_chan_b: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sf_frame) |-> $fell(sf_chan_b));

  a_r2_counters_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (sf_frame == 8'd0 && !sf_chan_b && hc == 6'd0));
endmodule

bind audio_subframe_tx audio_subframe_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_p(tx_p), .tx_n(tx_n), .sf_chan_b(sf_chan_b),
  .sf_frame(sf_frame), .tick(tick), .act(act), .hc(hc)
);

// File: tb/test_audio_subframe_tx.sv
`timescale 1ns/1ps
module test_audio_subframe_tx;
  localparam int SD = 5;
  localparam int NSF = 400;

  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, lr_mode = 1'b0;
  logic [1:0] mck_sel = 2'd0;
  logic audio_on = 1'b1, valid_bit = 1'b0, crc_en = 1'b0;
  logic [23:0] aud_a, aud_b;
  logic user_bit, cs_bit, tx_p, tx_n, sf_chan_b;
  logic [7:0] sf_frame;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  function automatic logic [23:0] exp_aud(input int fr, input int ch);
    logic [7:0] f;
    f = fr[7:0];
    return {f ^ 8'h5A, (ch != 0) ? 8'h3C : 8'hC3, f + 8'(ch * 7)};
  endfunction
  function automatic logic exp_cs(input int fr, input int ch);
    return ((fr * 3 + ch * 5) % 7) < 3;
  endfunction
  function automatic logic exp_u(input int fr, input int ch);
    return logic'(((fr >> 1) & 1) ^ ch);
  endfunction
  function automatic logic [7:0] exp_crc(input int ch);
    logic [7:0] c;
    logic fb;
    c = 8'hFF;
    for (int f = 0; f < 184; f++) begin
      fb = exp_cs(f, ch) ^ c[7];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    return c;
  endfunction

  assign aud_a    = exp_aud(int'(sf_frame), 0);
  assign aud_b    = exp_aud(int'(sf_frame), 1);
  assign cs_bit   = exp_cs(int'(sf_frame), int'(sf_chan_b));
  assign user_bit = exp_u(int'(sf_frame), int'(sf_chan_b));

  audio_subframe_tx #(.START_DLY(SD)) i_audio_subframe_tx (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .lr_mode(lr_mode), .mck_sel(mck_sel),
    .audio_on(audio_on), .valid_bit(valid_bit), .crc_en(crc_en), .aud_a(aud_a),
    .aud_b(aud_b), .user_bit(user_bit), .cs_bit(cs_bit), .tx_p(tx_p), .tx_n(tx_n),
    .sf_chan_b(sf_chan_b), .sf_frame(sf_frame)
  );

  // line decoder, valid at 1 half-cell per clock
  logic started = 1'b0, last_lvl = 1'b0;
  logic hcs [64];
  int hidx = 0, nsf = 0, viol = 0;
  logic [27:0] sf_dat [NSF];
  logic [1:0]  sf_pre [NSF];

  always @(negedge clk) begin
    if (tx_p == tx_n) begin
      started = 1'b0;
      hidx = 0;
    end else begin
      if (!started) begin
        started = 1'b1; hidx = 0; last_lvl = 1'b0;
      end
      hcs[hidx] = tx_p;
      hidx++;
      if (hidx == 64) begin
        logic [7:0] pat;
        logic [27:0] d;
        if (hcs[0] == last_lvl) viol++;
        for (int i = 0; i < 8; i++) pat[7-i] = hcs[i] ^ last_lvl;
        for (int s = 4; s < 32; s++) begin
          if (hcs[2*s] == hcs[2*s-1]) viol++;
          d[s-4] = hcs[2*s] != hcs[2*s+1];
        end
        if (nsf < NSF) begin
          sf_dat[nsf] = d;
          sf_pre[nsf] = (pat == 8'b11101000) ? 2'd0 : (pat == 8'b11100010) ? 2'd1 :
                        (pat == 8'b11100100) ? 2'd2 : 2'd3;
        end
        nsf++;
        last_lvl = hcs[63];
        hidx = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic boot(input bit lr, output int lat, output int early);
    rst_n = 1'b0; fsync = 1'b0; lr_mode = lr;
    repeat (3) @(negedge clk);
    check(tx_p == 1'b0 && tx_n == 1'b0, "R1", "outputs in reset", {tx_p, tx_n}, 0);
    nsf = 0; viol = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_p == 1'b0 && tx_n == 1'b0, "R1", "outputs before sync", {tx_p, tx_n}, 0);
    early = 0;
    if (lr) begin
      fsync = 1'b1;
      repeat (3 * SD) begin
        @(negedge clk);
        if (tx_p != tx_n) early++;
      end
      fsync = 1'b0;
    end else fsync = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (tx_p == tx_n && lat < 1000);
  endtask

  task automatic wait_sf(input int n);
    while (nsf < n) @(negedge clk);
  endtask

  task automatic test_startup();
    int lat, early;
    mck_sel = 2'd0;
    boot(1'b0, lat, early);
    check(lat == SD + 2, "R2", "start latency", lat, SD + 2);
  endtask

  task automatic test_lr_startup();
    int lat, early;
    mck_sel = 2'd0;
    boot(1'b1, lat, early);
    check(early == 0, "R3", "active during left half", early, 0);
    check(lat == SD + 2, "R3", "start latency after fall", lat, SD + 2);
    wait_sf(2);
    check(sf_pre[0] == 2'd0, "R3", "first subframe preamble", sf_pre[0], 0);
  endtask

  task automatic test_block_crc();
    int lat, early;
    logic [7:0] ca, cb, cc;
    mck_sel = 2'd0; audio_on = 1'b1; crc_en = 1'b1; valid_bit = 1'b0;
    ca = exp_crc(0); cb = exp_crc(1);
    boot(1'b0, lat, early);
    wait_sf(386);
    for (int n = 0; n < 386; n++) begin
      int fr, ch;
      logic [27:0] d;
      logic ec;
      fr = (n / 2) % 192; ch = n % 2; d = sf_dat[n];
      cc = (ch != 0) ? cb : ca;
      ec = (fr >= 184) ? cc[7 - (fr - 184)] : exp_cs(fr, ch);
      check(sf_pre[n] == ((ch != 0) ? 2'd2 : (fr == 0) ? 2'd0 : 2'd1), "R4", "preamble", sf_pre[n], n);
      check(d[23:0] == exp_aud(fr, ch), "R6", "audio field", d[23:0], exp_aud(fr, ch));
      check(d[24] == 1'b0, "R9", "validity", d[24], 0);
      check(d[25] == exp_u(fr, ch), "R6", "user slot", d[25], exp_u(fr, ch));
      check(d[26] == ec, "R10", "status slot with check byte", d[26], ec);
      check(^d == 1'b0, "R7", "even parity", d, 0);
    end
    check(viol == 0, "R5", "biphase transitions", viol, 0);
  endtask

  task automatic test_block_mute();
    int lat, early;
    mck_sel = 2'd0; audio_on = 1'b0; crc_en = 1'b0; valid_bit = 1'b1;
    boot(1'b0, lat, early);
    wait_sf(386);
    for (int n = 0; n < 386; n++) begin
      int fr, ch;
      logic [27:0] d;
      fr = (n / 2) % 192; ch = n % 2; d = sf_dat[n];
      check(d[23:0] == 24'd0, "R8", "muted audio", d[23:0], 0);
      check(d[24] == 1'b1, "R9", "validity", d[24], 1);
      check(d[25] == exp_u(fr, ch), "R8", "user slot under mute", d[25], exp_u(fr, ch));
      check(d[26] == exp_cs(fr, ch), "R10", "status slot, check off", d[26], exp_cs(fr, ch));
      check(^d == 1'b0, "R7", "even parity", d, 0);
    end
    check(viol == 0, "R5", "biphase transitions", viol, 0);
    audio_on = 1'b1; valid_bit = 1'b0;
  endtask

  task automatic test_ratio();
    for (int sel = 0; sel < 4; sel++) begin
      int lat, early, cnt, expv;
      logic prev;
      expv = (sel == 0) ? 128 : (sel == 1) ? 192 : (sel == 2) ? 256 : 384;
      mck_sel = 2'(sel);
      boot(1'b0, lat, early);
      prev = sf_chan_b;
      do begin
        @(negedge clk);
        if (sf_chan_b && !prev) break;
        prev = sf_chan_b;
      end while (1);
      cnt = 0;
      prev = sf_chan_b;
      do begin
        @(negedge clk);
        cnt++;
        if (sf_chan_b && !prev) break;
        prev = sf_chan_b;
      end while (cnt < 1000);
      check(cnt == expv, "R11", "frame length in clocks", cnt, expv);
    end
    mck_sel = 2'd0;
  endtask

  task automatic test_midreset();
    int lat, early;
    mck_sel = 2'd0; audio_on = 1'b1; crc_en = 1'b0;
    boot(1'b0, lat, early);
    wait_sf(7);
    rst_n = 1'b0;
    @(negedge clk);
    check(tx_p == 1'b0 && tx_n == 1'b0, "R12", "outputs on mid reset", {tx_p, tx_n}, 0);
    boot(1'b0, lat, early);
    wait_sf(2);
    check(sf_pre[0] == 2'd0, "R12", "block start after reset", sf_pre[0], 0);
    check(sf_dat[0][23:0] == exp_aud(0, 0), "R12", "frame 0 audio", sf_dat[0][23:0], exp_aud(0, 0));
    check(sf_pre[1] == 2'd2, "R12", "channel B follows", sf_pre[1], 2);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    test_startup();
    test_lr_startup();
    test_ratio();
    test_midreset();
    test_block_crc();
    test_block_mute();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule